// File: doc/BRIEF.md
# Outer-Product Multiply-Accumulate Tile (4 x 16)

This block holds a 4 by 16 grid of signed multiply-accumulate cells and builds one output tile of a matrix product. On every accepted beat it reads four elements of operand A (one per grid row) and sixteen elements of operand B (one per grid column). Every cell then adds the product of its row element and its column element to its own 32-bit accumulator, so each beat is a rank-1 update of the whole tile. A longer inner dimension is simply streamed as more beats.

A tile starts with a configuration pulse. The pulse zeroes all accumulators and captures two settings: the operand width (8 or 16 bit) and the result width (8, 16 or 32 bit). A beat is taken only when both operand streams offer data in the same cycle. A final-beat flag on either stream closes accumulation. The tile then leaves on the result port one row of sixteen values per cycle over four cycles, and the operand streams stay blocked until the next configuration pulse.

Top module: `mac_tile_4x16`

## Requirements
- R1: Reset is synchronous and active-high. After reset, `a_ready`, `b_ready` and `res_valid` are low.
- R2: A `cfg_start` pulse zeroes all 64 accumulators and raises both ready outputs from the next cycle. An operand beat offered in the same cycle as the pulse is discarded.
- R3: A beat is consumed only at a clock edge where `a_valid`, `b_valid` and the ready outputs are all high. A valid on one stream alone, or any beat while ready is low, leaves every accumulator unchanged.
- R4: Each consumed beat adds the signed product of A lane r (bits [16r+15:16r] of `a_data`) and B lane c (bits [16c+15:16c] of `b_data`) to cell (r,c). The 32-bit accumulator wraps in two's complement.
- R5: With `cfg_op_wide`=0, each lane uses only its low 8 bits, sign-extended, and its upper byte has no effect. With `cfg_op_wide`=1, all 16 bits are used.
- R6: A consumed beat with `a_last` or `b_last` high is the final beat of the tile. The ready outputs are low in the following cycle.
- R7: After the final beat, `res_valid` is high for exactly four consecutive cycles with `res_row` = 0, 1, 2, 3. The first of these cycles directly follows the cycle in which ready fell. Lane c of `res_data` is bits [32c+31:32c].
- R8: The ready outputs stay low during the drain and afterwards until the next `cfg_start`.
- R9: With `cfg_out_sel`=0 or 1, each result saturates to the signed 8-bit or 16-bit range and is sign-extended into its 32-bit lane. With `cfg_out_sel`=2, the lane carries the wrapped 32-bit accumulator.
- R10: `cfg_op_wide` and `cfg_out_sel` are sampled only with `cfg_start`. Changing them within a tile has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Clears the tile and captures the settings |
| cfg_op_wide | input | 1 | 1: 16-bit operands, 0: 8-bit operands |
| cfg_out_sel | input | 2 | Result width: 0 = 8, 1 = 16, 2 = 32 bit |
| a_valid | input | 1 | Operand A beat offered |
| a_ready | output | 1 | Tile accepts operand A |
| a_last | input | 1 | Final-beat flag on stream A |
| a_data | input | 64 | Four 16-bit A lanes |
| b_valid | input | 1 | Operand B beat offered |
| b_ready | output | 1 | Tile accepts operand B |
| b_last | input | 1 | Final-beat flag on stream B |
| b_data | input | 256 | Sixteen 16-bit B lanes |
| res_valid | output | 1 | Result row present |
| res_row | output | 2 | Index of the row on `res_data` |
| res_data | output | 512 | Sixteen 32-bit result lanes |

## Verification
Random 16-bit lanes at full width with a 32-bit result check the signed rank-1 arithmetic across all 64 cells. One-sided valid beats, and beats offered while the tile is idle, show whether a beat can slip in without both streams agreeing. Random lanes with junk in the upper byte, under 8-bit operand mode, show whether the narrow mode really ignores that byte. Extreme positive and negative operands are run under each result width: 8 and 16 bit must clip to the two signed limits, while 32 bit must show the wrapped sum. A final tile changes the width inputs between beats to confirm that only the captured settings are used.

// File: rtl/mac_tile_pkg.sv
package mac_tile_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_DRAIN = 2'd2
  } tile_state_e;

  typedef enum logic [1:0] {
    OUT_W8  = 2'd0,
    OUT_W16 = 2'd1,
    OUT_W32 = 2'd2
  } out_width_e;

endpackage

// File: rtl/mac_tile_cell.sv
module mac_tile_cell #(
  parameter int LANE_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     fire,
  input  logic                     op_wide,
  input  logic [LANE_W-1:0]        a_lane,
  input  logic [LANE_W-1:0]        b_lane,
  output logic signed [ACC_W-1:0]  acc
);
  localparam int HALF = LANE_W / 2;
  localparam int PW   = 2 * LANE_W;

  logic signed [LANE_W-1:0] a_op, b_op;
  logic signed [PW-1:0]     prod;

  // Narrow mode: the low half of each lane, sign-extended.
  always_comb begin
    a_op = op_wide ? $signed(a_lane) : LANE_W'($signed(a_lane[HALF-1:0]));
    b_op = op_wide ? $signed(b_lane) : LANE_W'($signed(b_lane[HALF-1:0]));
    prod = PW'(a_op) * PW'(b_op);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
    end else if (fire) begin
      acc <= acc + ACC_W'(prod);
    end
  end
endmodule

// File: rtl/mac_tile_sat.sv
module mac_tile_sat
  import mac_tile_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic signed [ACC_W-1:0] acc,
  input  out_width_e              sel,
  output logic [ACC_W-1:0]        res
);
  localparam logic signed [ACC_W-1:0] HI8  = 127;
  localparam logic signed [ACC_W-1:0] LO8  = -128;
  localparam logic signed [ACC_W-1:0] HI16 = 32767;
  localparam logic signed [ACC_W-1:0] LO16 = -32768;

  always_comb begin
    res = acc;
    case (sel)
      OUT_W8: begin
        if (acc > HI8)      res = HI8;
        else if (acc < LO8) res = LO8;
      end
      OUT_W16: begin
        if (acc > HI16)      res = HI16;
        else if (acc < LO16) res = LO16;
      end
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/mac_tile_ctrl.sv
module mac_tile_ctrl
  import mac_tile_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int RW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_start,
  input  logic          a_valid,
  input  logic          b_valid,
  input  logic          a_last,
  input  logic          b_last,
  output logic          intake,
  output logic          fire,
  output logic          drain_en,
  output logic [RW-1:0] drain_row
);
  tile_state_e   state;
  logic [RW-1:0] row_q;

  assign intake    = (state == ST_ACC);
  assign fire      = intake && a_valid && b_valid;
  assign drain_en  = (state == ST_DRAIN) && !cfg_start;
  assign drain_row = row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      row_q <= '0;
    end else if (cfg_start) begin
      state <= ST_ACC;
      row_q <= '0;
    end else begin
      case (state)
        ST_ACC: begin
          if (fire && (a_last || b_last)) begin
            state <= ST_DRAIN;
            row_q <= '0;
          end
        end
        ST_DRAIN: begin
          row_q <= row_q + 1'b1;
          if (row_q == RW'(ROWS - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_tile_4x16.sv
module mac_tile_4x16
  import mac_tile_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 16,
  parameter int LANE_W = 16,
  parameter int ACC_W  = 32,
  parameter int RW     = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_start,
  input  logic                     cfg_op_wide,
  input  logic [1:0]               cfg_out_sel,
  input  logic                     a_valid,
  output logic                     a_ready,
  input  logic                     a_last,
  input  logic [ROWS*LANE_W-1:0]   a_data,
  input  logic                     b_valid,
  output logic                     b_ready,
  input  logic                     b_last,
  input  logic [COLS*LANE_W-1:0]   b_data,
  output logic                     res_valid,
  output logic [RW-1:0]            res_row,
  output logic [COLS*ACC_W-1:0]    res_data
);
  logic          op_wide_q;
  out_width_e    out_sel_q;
  logic          intake, fire, drain_en;
  logic [RW-1:0] drain_row;

  logic signed [ACC_W-1:0] acc_q   [ROWS][COLS];
  logic signed [ACC_W-1:0] row_sel [COLS];
  logic [ACC_W-1:0]        sat_res [COLS];

  // Settings are captured only with the start pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      op_wide_q <= 1'b1;
      out_sel_q <= OUT_W32;
    end else if (cfg_start) begin
      op_wide_q <= cfg_op_wide;
      out_sel_q <= (cfg_out_sel == 2'd3) ? OUT_W32 : out_width_e'(cfg_out_sel);
    end
  end

  mac_tile_ctrl #(.ROWS(ROWS), .RW(RW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_start (cfg_start),
    .a_valid   (a_valid),
    .b_valid   (b_valid),
    .a_last    (a_last),
    .b_last    (b_last),
    .intake    (intake),
    .fire      (fire),
    .drain_en  (drain_en),
    .drain_row (drain_row)
  );

  assign a_ready = intake;
  assign b_ready = intake;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      mac_tile_cell #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .clear   (cfg_start),
        .fire    (fire),
        .op_wide (op_wide_q),
        .a_lane  (a_data[r*LANE_W +: LANE_W]),
        .b_lane  (b_data[c*LANE_W +: LANE_W]),
        .acc     (acc_q[r][c])
      );
    end
  end

  always_comb begin
    for (int c = 0; c < COLS; c++) row_sel[c] = acc_q[drain_row][c];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_sat
    mac_tile_sat #(.ACC_W(ACC_W)) u_sat (
      .acc (row_sel[c]),
      .sel (out_sel_q),
      .res (sat_res[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_row   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= drain_en;
      if (drain_en) begin
        res_row <= drain_row;
        for (int c = 0; c < COLS; c++) res_data[c*ACC_W +: ACC_W] <= sat_res[c];
      end
    end
  end
endmodule

// File: rtl/mac_tile_4x16_chk.sv
module mac_tile_4x16_chk #(
  parameter int ROWS  = 4,
  parameter int COLS  = 16,
  parameter int ACC_W = 32,
  parameter int RW    = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_start,
  input logic                  a_valid,
  input logic                  b_valid,
  input logic                  a_last,
  input logic                  b_last,
  input logic                  a_ready,
  input logic                  b_ready,
  input logic                  res_valid,
  input logic [RW-1:0]         res_row,
  input logic [COLS*ACC_W-1:0] res_data,
  input logic [1:0]            sel_q
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!a_ready && !b_ready && !res_valid));

  p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_start |=> (a_ready && b_ready));

  p_last_closes_r6: assert property (@(posedge clk) disable iff (rst)
    (a_ready && a_valid && b_valid && (a_last || b_last) && !cfg_start) |=> !a_ready);

  p_first_row_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> (res_row == '0));

  p_row_step_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_row != RW'(ROWS - 1) && !cfg_start)
      |=> (res_valid && res_row == RW'($past(res_row) + 1'b1)));

  p_closed_in_drain_r8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (!a_ready && !b_ready));

  for (genvar c = 0; c < COLS; c++) begin : g_lane
    logic signed [ACC_W-1:0] lane;
    assign lane = res_data[c*ACC_W +: ACC_W];

    p_clip8_r9: assert property (@(posedge clk) disable iff (rst)
      (res_valid && sel_q == 2'd0) |-> (lane <= 127 && lane >= -128));

    p_clip16_r9: assert property (@(posedge clk) disable iff (rst)
      (res_valid && sel_q == 2'd1) |-> (lane <= 32767 && lane >= -32768));
  end
endmodule

bind mac_tile_4x16 mac_tile_4x16_chk #(
  .ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W), .RW(RW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_start (cfg_start),
  .a_valid   (a_valid),
  .b_valid   (b_valid),
  .a_last    (a_last),
  .b_last    (b_last),
  .a_ready   (a_ready),
  .b_ready   (b_ready),
  .res_valid (res_valid),
  .res_row   (res_row),
  .res_data  (res_data),
  .sel_q     (out_sel_q)
);

// File: tb/mac_tile_4x16_tb.sv
module mac_tile_4x16_tb;
  localparam int ROWS = 4;
  localparam int COLS = 16;
  localparam int LW   = 16;
  localparam int AW   = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1;
  logic              cfg_start = 1'b0, cfg_op_wide = 1'b1;
  logic [1:0]        cfg_out_sel = 2'd2;
  logic              a_valid = 1'b0, a_last = 1'b0, b_valid = 1'b0, b_last = 1'b0;
  logic [ROWS*LW-1:0] a_data = '0;
  logic [COLS*LW-1:0] b_data = '0;
  logic              a_ready, b_ready, res_valid;
  logic [1:0]        res_row;
  logic [COLS*AW-1:0] res_data;

  mac_tile_4x16 u_dut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_op_wide(cfg_op_wide),
    .cfg_out_sel(cfg_out_sel), .a_valid(a_valid), .a_ready(a_ready), .a_last(a_last),
    .a_data(a_data), .b_valid(b_valid), .b_ready(b_ready), .b_last(b_last),
    .b_data(b_data), .res_valid(res_valid), .res_row(res_row), .res_data(res_data)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    cmp_on = 1'b0;
  string cur_tag = "R4";
  int    cycles = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic signed [31:0] m_acc [ROWS][COLS];
  int          m_mode = 0;   // 0 idle, 1 accumulating, 2 draining
  int          m_row  = 0;
  bit          m_wide = 1'b1;
  int          m_osel = 2;
  bit          m_rv   = 1'b0;
  int          m_rrow = 0;
  logic [31:0] m_rd [COLS];

  function automatic logic signed [31:0] opnd(logic [15:0] lane, bit wide);
    return wide ? {{16{lane[15]}}, lane} : {{24{lane[7]}}, lane[7:0]};
  endfunction

  function automatic logic [31:0] clip(logic signed [31:0] v, int sel);
    if (sel == 0) begin
      if (v > 127) return 32'd127;
      if (v < -128) return 32'hFFFF_FF80;
    end else if (sel == 1) begin
      if (v > 32767) return 32'd32767;
      if (v < -32768) return 32'hFFFF_8000;
    end
    return v;
  endfunction

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) m_acc[r][c] = '0;
    for (int c = 0; c < COLS; c++) m_rd[c] = '0;
  end

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_mode = 0; m_rv = 1'b0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) m_acc[r][c] = '0;
    end else if (cfg_start) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) m_acc[r][c] = '0;
      m_wide = cfg_op_wide; m_osel = int'(cfg_out_sel);
      m_mode = 1; m_rv = 1'b0;
    end else if (m_mode == 1) begin
      m_rv = 1'b0;
      if (a_valid && b_valid) begin
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++) begin
            logic signed [31:0] p;
            p = opnd(a_data[r*LW +: LW], m_wide) * opnd(b_data[c*LW +: LW], m_wide);
            m_acc[r][c] = m_acc[r][c] + p;
          end
        if (a_last || b_last) begin m_mode = 2; m_row = 0; end
      end
    end else if (m_mode == 2) begin
      m_rv = 1'b1; m_rrow = m_row;
      for (int c = 0; c < COLS; c++) m_rd[c] = clip(m_acc[m_row][c], m_osel);
      m_row++;
      if (m_row == ROWS) m_mode = 0;
    end else begin
      m_rv = 1'b0;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      bit exp_rdy;
      exp_rdy = (m_mode == 1);
      chk(a_ready === exp_rdy && b_ready === exp_rdy, (m_mode == 2) ? "R8" : "R3",
          "ready", {a_ready, b_ready}, {exp_rdy, exp_rdy});
      chk(res_valid === m_rv, "R7", "res_valid", res_valid, m_rv);
      if (m_rv) begin
        int bad;
        bad = -1;
        chk(res_row === 2'(m_rrow), "R7", "res_row", res_row, m_rrow);
        for (int c = 0; c < COLS; c++)
          if (bad < 0 && res_data[c*AW +: AW] !== m_rd[c]) bad = c;
        if (bad >= 0)
          chk(1'b0, cur_tag, $sformatf("row %0d lane %0d", m_rrow, bad),
              res_data[bad*AW +: AW], m_rd[bad]);
        else
          chk(1'b1, cur_tag, "row data", 0, 0);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [31:0] first_row [COLS];

  task automatic do_start(bit wide, logic [1:0] osel);
    cfg_start = 1'b1; cfg_op_wide = wide; cfg_out_sel = osel;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(a_ready === 1'b1 && b_ready === 1'b1, "R2", "ready after start", a_ready, 1);
  endtask

  task automatic beat(logic [ROWS*LW-1:0] ad, logic [COLS*LW-1:0] bd, bit av, bit bv, bit last);
    a_data = ad; b_data = bd; a_valid = av; b_valid = bv; a_last = last; b_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain_tile();
    int cnt;
    cnt = 0;
    a_valid = 1'b0; b_valid = 1'b0; a_last = 1'b0; b_last = 1'b0;
    chk(a_ready === 1'b0, "R6", "ready after final beat", a_ready, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (res_valid) begin
        cnt++;
        if (cnt == 1)
          for (int c = 0; c < COLS; c++) first_row[c] = res_data[c*AW +: AW];
        chk(a_ready === 1'b0, "R8", "ready during drain", a_ready, 0);
      end
    end
    chk(cnt == 4, "R7", "drained rows", cnt, 4);
  endtask

  function automatic logic [ROWS*LW-1:0] rnd_a();
    logic [ROWS*LW-1:0] v;
    for (int i = 0; i < ROWS; i++) v[i*LW +: LW] = 16'($urandom);
    return v;
  endfunction

  function automatic logic [COLS*LW-1:0] rnd_b();
    logic [COLS*LW-1:0] v;
    for (int i = 0; i < COLS; i++) v[i*LW +: LW] = 16'($urandom);
    return v;
  endfunction

  function automatic logic [COLS*LW-1:0] fill_b(logic [15:0] even, logic [15:0] odd);
    logic [COLS*LW-1:0] v;
    for (int i = 0; i < COLS; i++) v[i*LW +: LW] = (i % 2 == 0) ? even : odd;
    return v;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk(a_ready === 1'b0 && b_ready === 1'b0 && res_valid === 1'b0, "R1",
        "outputs in reset", {a_ready, b_ready, res_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(a_ready === 1'b0 && res_valid === 1'b0, "R1", "outputs after reset",
        {a_ready, res_valid}, 0);
    cmp_on = 1'b1;

    // R4 / R3: wide operands, 32-bit result, one-sided beats mixed in
    cur_tag = "R4";
    do_start(1'b1, 2'd2);
    beat(rnd_a(), rnd_b(), 1, 1, 0);
    beat(rnd_a(), rnd_b(), 1, 0, 0);
    beat(rnd_a(), rnd_b(), 1, 1, 0);
    beat(rnd_a(), rnd_b(), 0, 1, 1);
    beat(rnd_a(), rnd_b(), 1, 1, 1);
    drain_tile();

    // R3: beats while idle are not taken
    cur_tag = "R3";
    beat(rnd_a(), rnd_b(), 1, 1, 0);
    beat(rnd_a(), rnd_b(), 1, 1, 0);
    chk(a_ready === 1'b0, "R3", "idle ready", a_ready, 0);
    a_valid = 1'b0; b_valid = 1'b0;

    // R5: narrow operands with junk upper bytes, 16-bit results
    cur_tag = "R5";
    do_start(1'b0, 2'd1);
    for (int k = 0; k < 5; k++) beat(rnd_a(), rnd_b(), 1, 1, k == 4);
    drain_tile();

    // R9: clip to 8 bit
    cur_tag = "R9";
    do_start(1'b1, 2'd0);
    beat({ROWS{16'h7FFF}}, fill_b(16'h7FFF, 16'h8000), 1, 1, 1);
    drain_tile();
    chk(first_row[0] === 32'd127, "R9", "8-bit high clip", first_row[0], 127);
    chk(first_row[1] === 32'hFFFF_FF80, "R9", "8-bit low clip", first_row[1], 32'hFFFF_FF80);

    // R9: clip to 16 bit
    do_start(1'b1, 2'd1);
    beat({ROWS{16'h7FFF}}, fill_b(16'h7FFF, 16'h8000), 1, 1, 1);
    drain_tile();
    chk(first_row[0] === 32'd32767, "R9", "16-bit high clip", first_row[0], 32767);
    chk(first_row[1] === 32'hFFFF_8000, "R9", "16-bit low clip", first_row[1], 32'hFFFF_8000);

    // R9: 32-bit wraps, 3 x 2^30
    do_start(1'b1, 2'd2);
    for (int k = 0; k < 3; k++) beat({ROWS{16'h8000}}, {COLS{16'h8000}}, 1, 1, k == 2);
    drain_tile();
    chk(first_row[0] === 32'hC000_0000, "R9", "32-bit wrap", first_row[0], 32'hC000_0000);

    // R10: width inputs changed mid-tile are ignored
    cur_tag = "R10";
    do_start(1'b1, 2'd2);
    beat({ROWS{16'h0100}}, {COLS{16'h0001}}, 1, 1, 0);
    cfg_op_wide = 1'b0; cfg_out_sel = 2'd0;
    beat({ROWS{16'h0100}}, {COLS{16'h0001}}, 1, 1, 1);
    drain_tile();
    chk(first_row[0] === 32'd512, "R10", "captured settings kept", first_row[0], 512);

    // R2: start clears the previous tile
    cur_tag = "R2";
    do_start(1'b1, 2'd2);
    beat({ROWS{16'd3}}, {COLS{16'd5}}, 1, 1, 1);
    drain_tile();
    chk(first_row[0] === 32'd15, "R2", "accumulators cleared", first_row[0], 15);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule